// File: doc/BRIEF.md
# Filter Coefficient Load Port

This block is the write side of a coefficient store for an image filter. A host presents a 12-bit coefficient word and an 8-bit target address on two plain input buses, each qualified by its own active-low strobe that is sampled on the rising clock edge. The address is held in a register that changes only when its enable is low. Each coefficient is written into a small register bank at the address that register already holds.

Loading is guarded by an arming rule. A coefficient write can happen only after the load strobe has been sampled high and then sampled low. A strobe that is held low straight out of reset therefore writes nothing, and the host must drive it high after power-up before the first burst. Once armed, every clock edge with the strobe still low writes one more word, so the host can stream a burst by changing the address between edges.

The interface is strobe-qualified rather than valid/ready. The bank accepts one word per cycle unconditionally, so there is no back-pressure to express. A combinational read port returns any bank entry in the same cycle.

Top module: `coef_load_if`

## Requirements
- R1: After reset every bank entry reads 0 and the address register holds 0. A first armed load with no address capture lands in entry 0.
- R2: On a rising edge with `addr_en_n` low, `coef_addr_in` is copied into the address register. With `addr_en_n` high, the register keeps its value whatever `coef_addr_in` does.
- R3: If `load_n` has been low at every edge since reset, no entry is written.
- R4: On the first edge where `load_n` is sampled low after having been sampled high at the previous edge, `coef_in` is written to the entry named by the address register as it stood before that edge.
- R5: While `load_n` stays low after arming, each further edge writes `coef_in` to the current address register value. An address captured at the same edge takes effect from the next edge on.
- R6: An edge with `load_n` high writes nothing and clears the arming. The next low sample re-arms at once, because the high sample counts as the required preceding high.
- R7: A write to an address at or above the bank depth (16 by default) is discarded, and reads at such addresses return 0.
- R8: `rd_data` shows the entry at `rd_addr` combinationally, in the same cycle and without a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| coef_in | input | 12 | Coefficient word to store |
| coef_addr_in | input | 8 | Address to capture |
| load_n | input | 1 | Active-low coefficient load strobe |
| addr_en_n | input | 1 | Active-low address capture enable |
| rd_addr | input | 8 | Read address for the inspection port |
| rd_data | output | 12 | Bank entry at `rd_addr` (0 if out of range) |

## Verification
A wrong arming state shows at the ports as a bank entry that changes when it should not, or one that stays put when it should change. The bench sees this on the first full bank read after the offending edge. An address register that drifts or misses a capture sends the next write to a neighbouring entry. The bench compares every entry plus out-of-range addresses after each phase, so a stray write is caught no later than one phase after it happens. A write taken one edge early or late under a changing address lands in the wrong slot, and the burst phase is built to expose that.

// File: rtl/coef_if_pkg.sv
package coef_if_pkg;
  parameter int unsigned CIF_COEF_W = 12;
  parameter int unsigned CIF_ADDR_W = 8;
  parameter int unsigned CIF_DEPTH  = 16;

  // Per-edge write request passed from the top to the bank.
  typedef struct packed {
    logic                  fire;
    logic [CIF_ADDR_W-1:0] addr;
    logic [CIF_COEF_W-1:0] data;
  } cif_wreq_t;
endpackage

// File: rtl/cif_strobe_arm.sv
module cif_strobe_arm (
  input  logic clk,
  input  logic rst_n,
  input  logic load_n,
  output logic wr_fire
);
  logic prev_hi_q;   // load strobe was sampled high at the last edge
  logic armed_q;     // inside an armed burst

  // A write happens when the strobe is low and a high was seen first.
  assign wr_fire = !load_n && (armed_q || prev_hi_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_hi_q <= 1'b0;
      armed_q   <= 1'b0;
    end else begin
      prev_hi_q <= load_n;
      armed_q   <= wr_fire;
    end
  end

  // R6: a high strobe always drops the burst
  a_r6_high_disarms: assert property (@(posedge clk) disable iff (!rst_n)
    load_n |=> !armed_q);
  // R4: a falling edge arms the burst
  a_r4_fall_arms: assert property (@(posedge clk) disable iff (!rst_n)
    (prev_hi_q && !load_n) |=> armed_q);
endmodule

// File: rtl/cif_addr_reg.sv
module cif_addr_reg #(
  parameter int unsigned AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          addr_en_n,
  input  logic [AW-1:0] addr_in,
  output logic [AW-1:0] addr_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          addr_q <= '0;
    else if (!addr_en_n) addr_q <= addr_in;
  end

  // R2: holds while the enable is high
  a_r2_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    addr_en_n |=> $stable(addr_q));
endmodule

// File: rtl/cif_bank.sv
module cif_bank
  import coef_if_pkg::*;
#(
  parameter int unsigned CW    = CIF_COEF_W,
  parameter int unsigned AW    = CIF_ADDR_W,
  parameter int unsigned DEPTH = CIF_DEPTH
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [CW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [CW-1:0] rdata
);
  localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [CW-1:0] mem [DEPTH];
  logic          rd_in_range;
  logic          wr_in_range;

  assign rd_in_range = 32'(raddr) < DEPTH;
  assign wr_in_range = 32'(waddr) < DEPTH;

  for (genvar i = 0; i < DEPTH; i++) begin : g_entry
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                           mem[i] <= '0;
      else if (we && waddr == AW'(i))       mem[i] <= wdata;
    end
  end

  // R8: combinational read, zero outside the bank
  always_comb begin
    rdata = '0;
    if (rd_in_range) rdata = mem[raddr[IDX_W-1:0]];
  end

  // R4, R5: an in-range write is visible after the edge
  a_r4_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (we && wr_in_range) |=> mem[$past(waddr[IDX_W-1:0])] == $past(wdata));
endmodule

// File: rtl/coef_load_if.sv
module coef_load_if
  import coef_if_pkg::*;
#(
  parameter int unsigned COEF_W = CIF_COEF_W,
  parameter int unsigned ADDR_W = CIF_ADDR_W,
  parameter int unsigned DEPTH  = CIF_DEPTH
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [COEF_W-1:0] coef_in,
  input  logic [ADDR_W-1:0] coef_addr_in,
  input  logic              load_n,
  input  logic              addr_en_n,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [COEF_W-1:0] rd_data
);
  logic              wr_fire;
  logic [ADDR_W-1:0] addr_q;

  cif_strobe_arm u_arm (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_n  (load_n),
    .wr_fire (wr_fire)
  );

  cif_addr_reg #(.AW(ADDR_W)) u_addr (
    .clk       (clk),
    .rst_n     (rst_n),
    .addr_en_n (addr_en_n),
    .addr_in   (coef_addr_in),
    .addr_q    (addr_q)
  );

  cif_bank #(.CW(COEF_W), .AW(ADDR_W), .DEPTH(DEPTH)) u_bank (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (wr_fire),
    .waddr (addr_q),
    .wdata (coef_in),
    .raddr (rd_addr),
    .rdata (rd_data)
  );

  // R6: no write with the strobe high
  a_r6_no_write_high: assert property (@(posedge clk) disable iff (!rst_n)
    load_n |-> !wr_fire);
  // R3: the first write of a burst follows a high sample
  a_r3_burst_needs_high: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && !$past(wr_fire)) |-> $past(load_n));
  // R5: an armed burst keeps writing while the strobe stays low
  a_r5_burst_continues: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |=> (load_n || wr_fire));
endmodule

// File: tb/test_coef_load_if.sv
`timescale 1ns/1ps
module test_coef_load_if;
  localparam int CW = 12, AW = 8, DEPTH = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [CW-1:0] coef_in = '0;
  logic [AW-1:0] coef_addr_in = '0;
  logic          load_n = 1'b1;
  logic          addr_en_n = 1'b1;
  logic [AW-1:0] rd_addr = '0;
  logic [CW-1:0] rd_data;

  int checks = 0, errors = 0;
  bit done = 0;

  // bench model of the requirements
  logic [CW-1:0] m_mem [DEPTH];
  logic [AW-1:0] m_addr;
  bit m_prev_hi, m_armed;

  always #4 clk = ~clk;

  coef_load_if i_coef_load_if (
    .clk(clk), .rst_n(rst_n), .coef_in(coef_in), .coef_addr_in(coef_addr_in),
    .load_n(load_n), .addr_en_n(addr_en_n), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  task automatic check(string tag, logic [CW-1:0] act, logic [CW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: rd_addr=%0d actual=%h expected=%h", tag, rd_addr, act, exp);
    end
  endtask

  // one clock edge with the given inputs; model follows R2..R7
  task automatic step(bit ld, bit aen, logic [AW-1:0] adr, logic [CW-1:0] cf);
    @(negedge clk);
    load_n = ld; addr_en_n = aen; coef_addr_in = adr; coef_in = cf;
    @(posedge clk);
    if (!ld && (m_armed || m_prev_hi) && 32'(m_addr) < DEPTH) m_mem[m_addr] = cf;
    m_armed   = !ld && (m_armed || m_prev_hi);
    m_prev_hi = ld;
    if (!aen) m_addr = adr;
  endtask

  // R8: full sweep of reads within one low clock phase
  task automatic check_all(string tag);
    @(negedge clk);
    for (int a = 0; a < DEPTH + 2; a++) begin
      rd_addr = AW'(a); #0.2;
      check(tag, rd_data, m_mem[a % DEPTH] & {CW{a < DEPTH}});
    end
    rd_addr = 8'd255; #0.2;
    check({tag, "/R7"}, rd_data, '0);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) m_mem[i] = '0;
    m_addr = '0; m_prev_hi = 0; m_armed = 0;
    load_n = 1'b0;                       // held low through reset
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    check_all("R1");

    // R3: strobe low since reset, address moving, nothing written
    for (int k = 0; k < 6; k++) step(0, 0, AW'(k), CW'(12'h100 + k));
    check_all("R3");

    // R1: address register reset to 0 -> first load goes where captured? recheck:
    // release, capture nothing new, then address 0 via fresh reset path below
    step(1, 1, 8'd0, 12'h000);
    // R4: sweep every entry with a single-edge load after an address capture
    for (int a = 0; a < DEPTH; a++) begin
      step(1, 0, AW'(a), 12'h000);
      step(0, 1, 8'hFF, CW'(a * 257 + 3));
      step(1, 1, 8'h00, 12'hFFF);
    end
    check_all("R4");

    // R5: burst with address changing every edge (one-edge lag)
    step(1, 0, 8'd2, 12'h000);
    for (int k = 0; k < 8; k++) step(0, 0, AW'(k + 5), CW'(12'hA00 + k * 17));
    step(1, 1, 8'd0, 12'h000);
    check_all("R5");

    // R2: address enable high, address bus wiggling, writes stay at 9
    step(1, 0, 8'd9, 12'h000);
    for (int k = 0; k < 4; k++) step(0, 1, AW'(k), CW'(12'h5C0 + k));
    check_all("R2");

    // R6: strobe high with data and address moving: nothing written
    for (int k = 0; k < 10; k++) step(1, k[0], AW'(k), CW'(12'h3F0 + k));
    check_all("R6");
    // R6: alternating high/low re-arms on every low sample
    for (int k = 0; k < 6; k++) step(k[0], 0, AW'(k + 1), CW'(12'h770 + k));
    step(1, 1, 8'd0, 12'h000);
    check_all("R6");

    // R7: out-of-range address discards writes
    step(1, 0, 8'd16, 12'h000);
    step(0, 1, 8'd0, 12'hBAD);
    step(0, 0, 8'd200, 12'hBAD);
    step(0, 1, 8'd0, 12'hDAD);
    step(1, 1, 8'd0, 12'h000);
    check_all("R7");

    // R1: fresh reset clears bank and address, first armed load lands in 0
    @(negedge clk); rst_n = 1'b0; load_n = 1'b1;
    for (int i = 0; i < DEPTH; i++) m_mem[i] = '0;
    m_addr = '0; m_prev_hi = 0; m_armed = 0;
    @(negedge clk); rst_n = 1'b1;
    check_all("R1");
    step(1, 1, 8'd7, 12'h000);
    step(0, 1, 8'd7, 12'h4E1);
    step(1, 1, 8'd7, 12'h000);
    check_all("R1");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule